// File: doc/BRIEF.md
# Buffered-Update Pulse-Width Modulation Channel

This block is one pulse-width modulation channel. A free-running prescaler divides the input clock by a power of two, and a period counter counts prescaled ticks from zero up to the programmed period. A compare against the active threshold produces the waveform. Each period opens at the inactive level. The output turns active once the count reaches the threshold, so the active time is the period minus the threshold. A polarity bit can invert the waveform.

Period, threshold and mode are taken directly from the inputs while the channel is stopped. While the channel runs, new threshold and period values can only arrive through update strobes. These values are held in a buffer and take effect at the next period boundary, so a running period is never cut short. A parameter selects the update layout. In the split layout, the threshold and the period each have their own update strobe. In the shared layout, one strobe serves both, and mode bit 10 steers it. A one-cycle pulse marks the first cycle of every period, so the controlling logic can see when a buffered value has been taken up.

Top module: `pwm_chan_top`

## Requirements
- R1: While reset is asserted, and in the cycles after it with the channel off, `running_o`, `period_start_o` and `pwm_o` are all 0.
- R2: The counter advances once every 2^p input clock cycles, where p is mode bits [3:0]. Values of p above 10 act as 10.
- R3: One period lasts `period` counter steps, so it is period × 2^p clock cycles. A period value of 0 acts as 1.
- R4: Each period starts at the inactive level. The output is active in every step whose count is at or above the threshold, which gives (period − threshold) × 2^p active cycles. A threshold of 0 is active for the whole period. A threshold at or above the period is never active.
- R5: Mode bit 9 sets the polarity. With 0, active is `pwm_o`=1. With 1, active is `pwm_o`=0.
- R6: A threshold update made while running leaves the current period unchanged and is used from the next period on. An update strobed in the last cycle of a period (the wrap cycle) takes effect at that same wrap.
- R7: In the split layout (`SHARED_UPD`=0), `upd_per_we_i` buffers a new period and `upd_duty_we_i` buffers a new threshold. In the shared layout (`SHARED_UPD`=1), `upd_duty_we_i` is the only strobe: it targets the threshold when mode bit 10 is 0 and the period when it is 1.
- R8: `period_start_o` is high for exactly one cycle. That cycle is the first cycle of every period, including the first cycle after the channel is enabled.
- R9: With `ch_en_i` low, the channel does the following one cycle later: `running_o` goes to 0, the counter returns to 0, the output sits at the inactive level, and update strobes are dropped. Period, threshold and mode are taken from the inputs only while the channel is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_en_i | input | 1 | Channel run enable |
| mode_i | input | 11 | [3:0] prescale exponent, [9] polarity, [10] shared-update target |
| period_i | input | W | Period, taken while stopped |
| duty_i | input | W | Activation threshold, taken while stopped |
| upd_data_i | input | W | Data for buffered updates |
| upd_duty_we_i | input | 1 | Threshold update strobe (shared strobe in shared layout) |
| upd_per_we_i | input | 1 | Period update strobe (split layout only) |
| pwm_o | output | 1 | Waveform |
| running_o | output | 1 | Channel is counting |
| period_start_o | output | 1 | One-cycle pulse on the first cycle of each period |

## Verification
The bench targets the threshold extremes: a threshold of 0, a threshold equal to the period, and a threshold above the period. An off-by-one compare would show up here as one step of active level too many or too few, or as a glitch at the start of a period. It also targets a period of 0 or 1 and a prescale exponent above 10. A missing clamp would stretch the period or freeze the counter. Buffered updates are strobed both in mid-period and exactly in the wrap cycle. A design that applies them at once would change the running period. A design that ignores a write landing on the wrap would delay it by a whole period. The bench also checks the shared layout's target bit, and it checks that updates strobed while the channel is stopped are dropped rather than left in the buffer.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int MODE_W      = 11;
  localparam int PSC_LSB     = 0;
  localparam int PSC_FIELD_W = 4;
  localparam int POL_BIT     = 9;
  localparam int UPD_SEL_BIT = 10;
  localparam int PSC_MAX     = 10;

  function automatic logic [PSC_FIELD_W-1:0] clamp_psc(input logic [PSC_FIELD_W-1:0] p);
    return (p > PSC_FIELD_W'(PSC_MAX)) ? PSC_FIELD_W'(PSC_MAX) : p;
  endfunction
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int PSC_W = 4,
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic [PSC_W-1:0] psc_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] div_q, div_n, mask;

  always_comb begin
    mask   = {DIV_W{1'b1}} >> (DIV_W - int'(psc_i));
    tick_o = go_i && ((div_q & mask) == mask);
    div_n  = go_i ? div_q + DIV_W'(1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_n;
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && psc_i != '0) |=> !tick_o); // R2
endmodule

// File: rtl/pwm_period_counter.sv
module pwm_period_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go_i,
  input  logic         tick_i,
  input  logic [W-1:0] per_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q, cnt_n, per_eff;
  logic         last;

  always_comb begin
    per_eff = (per_i == '0) ? W'(1) : per_i;
    last    = (cnt_q >= per_eff - W'(1));
    wrap_o  = go_i && tick_i && last;
    cnt_n   = cnt_q;
    if (!go_i)       cnt_n = '0;
    else if (tick_i) cnt_n = last ? '0 : cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign cnt_o = cnt_q;

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |-> (cnt_q < per_eff)); // R3
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> (cnt_q == '0)); // R3
endmodule

// File: rtl/pwm_update_buffer.sv
module pwm_update_buffer #(
  parameter int W          = 16,
  parameter bit SHARED_UPD = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         acc_i,
  input  logic         apply_i,
  input  logic [W-1:0] period_i,
  input  logic [W-1:0] duty_i,
  input  logic [W-1:0] upd_data_i,
  input  logic         upd_duty_we_i,
  input  logic         upd_per_we_i,
  input  logic         sel_per_i,
  output logic [W-1:0] act_per_o,
  output logic [W-1:0] act_duty_o
);
  logic         duty_we, per_we;
  logic [W-1:0] act_per_q, act_per_n, act_duty_q, act_duty_n;
  logic [W-1:0] pend_per_q, pend_per_n, pend_duty_q, pend_duty_n;
  logic         pend_pv_q, pend_pv_n, pend_dv_q, pend_dv_n;

  generate
    if (SHARED_UPD) begin : g_shared
      logic unused_split_we;
      assign unused_split_we = upd_per_we_i;
      assign duty_we = upd_duty_we_i && !sel_per_i;
      assign per_we  = upd_duty_we_i &&  sel_per_i;
    end else begin : g_split
      logic unused_sel;
      assign unused_sel = sel_per_i;
      assign duty_we = upd_duty_we_i;
      assign per_we  = upd_per_we_i;
    end
  endgenerate

  always_comb begin
    act_per_n   = act_per_q;
    act_duty_n  = act_duty_q;
    pend_per_n  = pend_per_q;
    pend_duty_n = pend_duty_q;
    pend_pv_n   = pend_pv_q;
    pend_dv_n   = pend_dv_q;
    if (load_i) begin
      act_per_n  = period_i;
      act_duty_n = duty_i;
      pend_pv_n  = 1'b0;
      pend_dv_n  = 1'b0;
    end else if (acc_i) begin
      if (duty_we) begin
        pend_duty_n = upd_data_i;
        pend_dv_n   = 1'b1;
      end
      if (per_we) begin
        pend_per_n = upd_data_i;
        pend_pv_n  = 1'b1;
      end
      if (apply_i) begin
        if (pend_dv_n) act_duty_n = pend_duty_n;
        if (pend_pv_n) act_per_n  = pend_per_n;
        pend_dv_n = 1'b0;
        pend_pv_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_per_q   <= '0;
      act_duty_q  <= '0;
      pend_per_q  <= '0;
      pend_duty_q <= '0;
      pend_pv_q   <= 1'b0;
      pend_dv_q   <= 1'b0;
    end else begin
      act_per_q   <= act_per_n;
      act_duty_q  <= act_duty_n;
      pend_per_q  <= pend_per_n;
      pend_duty_q <= pend_duty_n;
      pend_pv_q   <= pend_pv_n;
      pend_dv_q   <= pend_dv_n;
    end
  end

  assign act_per_o  = act_per_q;
  assign act_duty_o = act_duty_q;

  AST_DUTY_HELD_MIDPERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_i && !apply_i && !load_i) |=> ($stable(act_duty_q) && $stable(act_per_q))); // R6
  AST_PEND_CLEARED_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_i && apply_i && !load_i) |=> (!pend_dv_q && !pend_pv_q)); // R6
endmodule

// File: rtl/pwm_chan_top.sv
module pwm_chan_top
  import pwm_pkg::*;
#(
  parameter int W          = 16,
  parameter bit SHARED_UPD = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ch_en_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [W-1:0]      period_i,
  input  logic [W-1:0]      duty_i,
  input  logic [W-1:0]      upd_data_i,
  input  logic              upd_duty_we_i,
  input  logic              upd_per_we_i,
  output logic              pwm_o,
  output logic              running_o,
  output logic              period_start_o
);
  localparam int DIV_W = PSC_MAX;

  logic                   rst_meta_q, rst_sync_q;
  logic                   run_q, start_q, start_n;
  logic                   pol_q, pol_n, sel_q, sel_n;
  logic [PSC_FIELD_W-1:0] psc_q, psc_n;
  logic                   go, tick, wrap, load;
  logic [W-1:0]           cnt, act_per, act_duty;
  logic                   unused_mode_bits;

  assign unused_mode_bits = ^mode_i[POL_BIT-1:PSC_LSB+PSC_FIELD_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign go   = ch_en_i && run_q;
  assign load = !run_q;

  always_comb begin
    psc_n   = psc_q;
    pol_n   = pol_q;
    sel_n   = sel_q;
    if (load) begin
      psc_n = clamp_psc(mode_i[PSC_LSB +: PSC_FIELD_W]);
      pol_n = mode_i[POL_BIT];
      sel_n = mode_i[UPD_SEL_BIT];
    end
    start_n = ch_en_i && (!run_q || wrap);
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      run_q   <= 1'b0;
      start_q <= 1'b0;
      psc_q   <= '0;
      pol_q   <= 1'b0;
      sel_q   <= 1'b0;
    end else begin
      run_q   <= ch_en_i;
      start_q <= start_n;
      psc_q   <= psc_n;
      pol_q   <= pol_n;
      sel_q   <= sel_n;
    end
  end

  pwm_prescaler #(.PSC_W(PSC_FIELD_W), .DIV_W(DIV_W)) u_psc (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .go_i   (go),
    .psc_i  (psc_q),
    .tick_o (tick)
  );

  pwm_period_counter #(.W(W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .go_i   (go),
    .tick_i (tick),
    .per_i  (act_per),
    .cnt_o  (cnt),
    .wrap_o (wrap)
  );

  pwm_update_buffer #(.W(W), .SHARED_UPD(SHARED_UPD)) u_buf (
    .clk           (clk),
    .rst_n         (rst_sync_q),
    .load_i        (load),
    .acc_i         (go),
    .apply_i       (wrap),
    .period_i      (period_i),
    .duty_i        (duty_i),
    .upd_data_i    (upd_data_i),
    .upd_duty_we_i (upd_duty_we_i),
    .upd_per_we_i  (upd_per_we_i),
    .sel_per_i     (sel_q),
    .act_per_o     (act_per),
    .act_duty_o    (act_duty)
  );

  assign pwm_o          = (run_q && (cnt >= act_duty)) ^ pol_q;
  assign running_o      = run_q;
  assign period_start_o = start_q;

  AST_START_WHILE_RUNNING: assert property (@(posedge clk) disable iff (!rst_sync_q)
    period_start_o |-> running_o); // R8
  AST_START_AT_COUNT_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_q)
    period_start_o |-> (cnt == '0)); // R8
  AST_STOP_FOLLOWS_ENABLE: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !$past(ch_en_i) |-> (!running_o && !period_start_o)); // R9
  AST_IDLE_INACTIVE: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !running_o |-> (pwm_o == pol_q)); // R9
endmodule

// File: tb/pwm_chan_top_tb_top.sv
module pwm_chan_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int NV = 9;

  typedef struct packed {
    logic [3:0]  psc;
    logic        pol;
    logic [15:0] per;
    logic [15:0] duty;
    logic [15:0] exp_len;
    logic [15:0] exp_hi;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{4'd0,  1'b0, 16'd10, 16'd4, 16'd10,   16'd6},
    '{4'd0,  1'b1, 16'd8,  16'd0, 16'd8,    16'd8},
    '{4'd1,  1'b0, 16'd6,  16'd2, 16'd12,   16'd8},
    '{4'd2,  1'b1, 16'd5,  16'd5, 16'd20,   16'd0},
    '{4'd0,  1'b0, 16'd4,  16'd9, 16'd4,    16'd0},
    '{4'd3,  1'b0, 16'd3,  16'd1, 16'd24,   16'd16},
    '{4'd0,  1'b0, 16'd1,  16'd0, 16'd1,    16'd1},
    '{4'd12, 1'b0, 16'd2,  16'd1, 16'd2048, 16'd1024},
    '{4'd0,  1'b0, 16'd0,  16'd0, 16'd1,    16'd1}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ch_en;
  logic [10:0]   mode;
  logic [W-1:0]  period, duty, upd_data;
  logic          upd_duty_we, upd_per_we;
  logic          pwm0, run0, st0, pwm1, run1, st1;
  logic          cur_pol;
  int            nchk = 0;
  int            nfail = 0;
  bit            done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_chan_top #(.W(W), .SHARED_UPD(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .ch_en_i(ch_en), .mode_i(mode),
    .period_i(period), .duty_i(duty), .upd_data_i(upd_data),
    .upd_duty_we_i(upd_duty_we), .upd_per_we_i(upd_per_we),
    .pwm_o(pwm0), .running_o(run0), .period_start_o(st0));

  pwm_chan_top #(.W(W), .SHARED_UPD(1'b1)) dut_sh_i (
    .clk(clk), .rst_n(rst_n), .ch_en_i(ch_en), .mode_i(mode),
    .period_i(period), .duty_i(duty), .upd_data_i(upd_data),
    .upd_duty_we_i(upd_duty_we), .upd_per_we_i(upd_per_we),
    .pwm_o(pwm1), .running_o(run1), .period_start_o(st1));

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic start_of(input int s);
    return (s != 0) ? st1 : st0;
  endfunction

  function automatic logic active_of(input int s);
    return ((s != 0) ? pwm1 : pwm0) ^ cur_pol;
  endfunction

  task automatic program_ch(input logic [3:0] psc, input logic pol, input logic sel,
                            input logic [W-1:0] per, input logic [W-1:0] dt);
    ch_en = 1'b0;
    repeat (3) @(negedge clk);
    mode = '0;
    mode[3:0] = psc;
    mode[9] = pol;
    mode[10] = sel;
    cur_pol = pol;
    period = per;
    duty = dt;
    repeat (2) @(negedge clk);
  endtask

  // Called at a negedge. Waits for a start pulse, then counts one period.
  // An update strobe is issued at offset wr_off within the period.
  task automatic measure(input int s, input int wr_off, input logic wd, input logic wp,
                         input logic [W-1:0] wdat, output int len, output int hi);
    int guard = 0;
    while (!start_of(s) && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    len = 0;
    hi = 0;
    do begin
      if (active_of(s)) hi++;
      if (len == wr_off) begin
        upd_duty_we = wd;
        upd_per_we = wp;
        upd_data = wdat;
      end
      len++;
      @(negedge clk);
      upd_duty_we = 1'b0;
      upd_per_we = 1'b0;
    end while (!start_of(s) && len < 5000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int len, hi;
    rst_n = 1'b0;
    ch_en = 1'b0;
    mode = '0;
    period = '0;
    duty = '0;
    upd_data = '0;
    upd_duty_we = 1'b0;
    upd_per_we = 1'b0;
    cur_pol = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    chk("R1 running in reset", int'(run0), 0);
    chk("R1 start in reset", int'(st0), 0);
    chk("R1 pwm in reset", int'(pwm0), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 running after reset", int'(run0), 0);
    chk("R1 pwm after reset", int'(pwm0), 0);

    // Vector table: R2 R3 R4 R5 R8 R9
    for (int v = 0; v < NV; v++) begin
      program_ch(VECS[v].psc, VECS[v].pol, 1'b0, VECS[v].per, VECS[v].duty);
      chk("R9 idle inactive level", int'(pwm0), int'(VECS[v].pol));
      chk("R9 idle not running", int'(run0), 0);
      ch_en = 1'b1;
      @(negedge clk);
      chk("R8 start on first cycle", int'(st0), 1);
      chk("R5 R4 first cycle level", int'(pwm0),
          int'(VECS[v].pol ^ (VECS[v].duty == 16'd0)));
      measure(0, -1, 1'b0, 1'b0, '0, len, hi);
      chk("R2 R3 period length", len, int'(VECS[v].exp_len));
      chk("R4 R5 active cycles", hi, int'(VECS[v].exp_hi));
      measure(0, -1, 1'b0, 1'b0, '0, len, hi);
      chk("R3 R8 second period length", len, int'(VECS[v].exp_len));
    end

    // R8: start pulse is a single cycle with prescale 2
    program_ch(4'd2, 1'b0, 1'b0, 16'd4, 16'd2);
    ch_en = 1'b1;
    @(negedge clk);
    chk("R8 pulse high", int'(st0), 1);
    @(negedge clk);
    chk("R8 pulse one cycle", int'(st0), 0);

    // R6: mid-period update held to the next period
    program_ch(4'd0, 1'b0, 1'b0, 16'd10, 16'd8);
    ch_en = 1'b1;
    @(negedge clk);
    measure(0, 2, 1'b1, 1'b0, 16'd3, len, hi);
    chk("R6 current period unchanged", hi, 2);
    measure(0, -1, 1'b0, 1'b0, '0, len, hi);
    chk("R6 next period updated", hi, 7);
    // R6: update strobed on the wrap cycle applies at that wrap
    measure(0, 9, 1'b1, 1'b0, 16'd6, len, hi);
    chk("R6 wrap-cycle write period", hi, 7);
    measure(0, -1, 1'b0, 1'b0, '0, len, hi);
    chk("R6 wrap-cycle write applied", hi, 4);

    // R7: split layout period update
    measure(0, 3, 1'b0, 1'b1, 16'd6, len, hi);
    chk("R7 split period held", len, 10);
    measure(0, -1, 1'b0, 1'b0, '0, len, hi);
    chk("R7 split period applied", len, 6);
    chk("R7 split duty kept", hi, 0);

    // R7: shared layout, target bit 0 -> threshold
    program_ch(4'd0, 1'b0, 1'b0, 16'd10, 16'd8);
    ch_en = 1'b1;
    @(negedge clk);
    measure(1, 1, 1'b1, 1'b0, 16'd5, len, hi);
    measure(1, -1, 1'b0, 1'b0, '0, len, hi);
    chk("R7 shared sel0 duty", hi, 5);
    chk("R7 shared sel0 period kept", len, 10);
    // R7: shared layout, target bit 1 -> period
    program_ch(4'd0, 1'b0, 1'b1, 16'd10, 16'd8);
    ch_en = 1'b1;
    @(negedge clk);
    measure(1, 1, 1'b1, 1'b0, 16'd12, len, hi);
    measure(1, -1, 1'b0, 1'b0, '0, len, hi);
    chk("R7 shared sel1 period", len, 12);
    chk("R7 shared sel1 duty kept", hi, 4);

    // R9: updates while stopped are dropped
    program_ch(4'd0, 1'b0, 1'b0, 16'd10, 16'd7);
    upd_data = 16'd1;
    upd_duty_we = 1'b1;
    @(negedge clk);
    upd_duty_we = 1'b0;
    ch_en = 1'b1;
    @(negedge clk);
    measure(0, -1, 1'b0, 1'b0, '0, len, hi);
    chk("R9 stopped write dropped p1", hi, 3);
    measure(0, -1, 1'b0, 1'b0, '0, len, hi);
    chk("R9 stopped write dropped p2", hi, 3);

    // R9: disable mid-run with inverted polarity
    program_ch(4'd0, 1'b1, 1'b0, 16'd6, 16'd0);
    ch_en = 1'b1;
    repeat (3) @(negedge clk);
    chk("R5 inverted active is low", int'(pwm0), 0);
    ch_en = 1'b0;
    @(negedge clk);
    chk("R9 running cleared", int'(run0), 0);
    chk("R9 output inactive", int'(pwm0), 1);
    repeat (5) @(negedge clk);
    chk("R9 output stays inactive", int'(pwm0), 1);
    ch_en = 1'b1;
    @(negedge clk);
    chk("R9 restart from zero start", int'(st0), 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule